// File: doc/BRIEF.md
# Two-Class Partitioned Read Command Queue

This block stores read commands for a memory controller while they wait for a downstream scheduler. Several requesting ports feed it. A configuration bit for each port marks that port's reads as high priority or low priority. Every accepted command is filed in the class of the port that sent it. A shared storage array holds all usable entries, and a programmable boundary divides it between the two classes. One extra slot sits outside the array. It takes only commands from a dedicated internal error-correction input, so those commands never use a class credit.

Each class keeps a credit counter, which equals its occupancy, and compares it with its share of the array. A port whose class has no free credit sees its ready held low. The other class keeps flowing. Within a class, commands leave in arrival order. The scheduler sees the oldest command of each class and of the reserved slot, and removes it with a pop strobe. The boundary setting takes effect only while both classes are empty. While either class holds a command, the boundary in use stays frozen.

A high-priority port gets no storage until the low-priority share is lowered below the usable total. The default share gives every usable entry to the low-priority class.

Top module: `rdq_split`

## Requirements
- R1: With `U = TOTAL_SLOTS - 1` usable entries and boundary `B = min(cfg_lo_entries, U)`, the low-priority class accepts at most `B` stored commands and the high-priority class at most `U - B`; a setting above `U` acts as `U`.
- R2: A command from port `p` is filed as high priority when `cfg_port_hp[p]` is 1, and as low priority when it is 0; the head port field reports `p`.
- R3: `req_ready[p]` is 1 exactly when the class of port `p` holds fewer commands than its share and no lower-numbered port of the same class has `req_valid` high. A stalled class does not lower ready for ports of the other class.
- R4: Within each class, commands leave in the order they were accepted; the head outputs show the address and port of the oldest one.
- R5: A pop on a non-empty class removes its head and frees one credit, which ready reflects from the next cycle; a pop on an empty class has no effect.
- R6: The boundary follows `cfg_lo_entries` only on cycles where both classes are empty; otherwise the value from the last empty cycle stays in force.
- R7: The reserved slot holds one command from the error-correction input, with `ecc_req_ready` equal to the slot being empty; it never changes either class's credits or ready.
- R8: After reset, both classes and the reserved slot are empty and all head valid outputs are 0.
- R9: Ready depends on the occupancy at the start of the cycle, so a class at its limit stays stalled in the cycle of a pop, and reopens in the next.
- R10: In one cycle, the block can accept one low-priority and one high-priority command together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_port_hp | input | NUM_PORTS | Per-port high-priority select |
| cfg_lo_entries | input | CNT_W | Requested low-priority share of the usable entries |
| req_valid | input | NUM_PORTS | Per-port command valid |
| req_addr | input | NUM_PORTS*ADDR_W | Per-port command address, port p at bits p*ADDR_W upward |
| req_ready | output | NUM_PORTS | Per-port accept |
| ecc_req_valid | input | 1 | Error-correction command valid |
| ecc_req_addr | input | ADDR_W | Error-correction command address |
| ecc_req_ready | output | 1 | Reserved slot free |
| lo_head_valid | output | 1 | Low-priority class non-empty |
| lo_head_addr | output | ADDR_W | Oldest low-priority address |
| lo_head_port | output | PORT_W | Oldest low-priority source port |
| lo_pop | input | 1 | Remove low-priority head |
| hi_head_valid | output | 1 | High-priority class non-empty |
| hi_head_addr | output | ADDR_W | Oldest high-priority address |
| hi_head_port | output | PORT_W | Oldest high-priority source port |
| hi_pop | input | 1 | Remove high-priority head |
| ecc_head_valid | output | 1 | Reserved slot occupied |
| ecc_head_addr | output | ADDR_W | Reserved slot address |
| ecc_pop | input | 1 | Empty the reserved slot |

## Verification
The bench builds the block with four ports, 8-bit addresses and seven total slots. That leaves six usable entries and a 3-bit boundary field, so the setting 7 exercises the clamp. With only six entries, every boundary value from zero to beyond the usable count can be swept. Each class reaches its limit, wraps its ring several times and drains to empty within a few dozen cycles. This drives boundary changes both while the queue is busy and while it is idle. A reference model predicts every ready bit and head field on every cycle from queue contents and the boundary.

// File: rtl/rdq_pkg.sv
package rdq_pkg;

   typedef enum logic {
      CLS_LO = 1'b0,
      CLS_HI = 1'b1
   } rdq_class_e;

   function automatic int clamp_share(input int want, input int cap);
      return (want > cap) ? cap : want;
   endfunction

endpackage

// File: rtl/rdq_credit.sv
module rdq_credit #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] limit,
   input  logic             push,
   input  logic             pop,
   output logic             has_credit,
   output logic             empty
);

   logic [CNT_W-1:0] held_q;
   logic             pop_ok;

   assign empty      = (held_q == '0);
   assign pop_ok     = pop && !empty;
   assign has_credit = (held_q < limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= '0;
      end else begin
         case ({push, pop_ok})
            2'b10:   held_q <= held_q + 1'b1;
            2'b01:   held_q <= held_q - 1'b1;
            default: held_q <= held_q;
         endcase
      end
   end

   p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      held_q <= limit);

   p_push_needs_credit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> has_credit);

   p_pop_empty_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> empty);

endmodule

// File: rtl/rdq_ring.sv
module rdq_ring #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [CNT_W-1:0] base,
   input  logic [CNT_W-1:0] size,
   input  logic             push,
   input  logic             pop,
   output logic [CNT_W-1:0] wr_idx,
   output logic [CNT_W-1:0] rd_idx
);

   logic [CNT_W-1:0] wr_off_q, rd_off_q;
   logic [CNT_W-1:0] wr_cur, rd_cur;

   function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v,
                                             input logic [CNT_W-1:0] lim);
      logic [CNT_W:0] nx;
      nx = {1'b0, v} + {{CNT_W{1'b0}}, 1'b1};
      return (nx == {1'b0, lim}) ? '0 : nx[CNT_W-1:0];
   endfunction

   assign wr_cur = flush ? '0 : wr_off_q;
   assign rd_cur = flush ? '0 : rd_off_q;
   assign wr_idx = base + wr_cur;
   assign rd_idx = base + rd_cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_off_q <= '0;
         rd_off_q <= '0;
      end else begin
         wr_off_q <= push ? step(wr_cur, size) : wr_cur;
         rd_off_q <= pop  ? step(rd_cur, size) : rd_cur;
      end
   end

   p_wr_in_region_r1: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (wr_cur < size));

   p_rd_in_region_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (rd_cur < size));

endmodule

// File: rtl/rdq_resv_slot.sv
module rdq_resv_slot #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              in_ready,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr,
   input  logic              out_pop
);

   logic              full_q;
   logic [ADDR_W-1:0] addr_q;
   logic              take;

   assign take      = in_valid && !full_q;
   assign in_ready  = !full_q;
   assign out_valid = full_q;
   assign out_addr  = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
      end else if (take) begin
         full_q <= 1'b1;
      end else if (out_pop) begin
         full_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (take) begin
         addr_q <= in_addr;
      end
   end

   p_slot_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !out_pop) |=> (full_q && $stable(addr_q)));

   p_slot_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && out_pop) |=> !out_valid);

endmodule

// File: rtl/rdq_split.sv
module rdq_split
   import rdq_pkg::*;
#(
   parameter int NUM_PORTS   = 4,
   parameter int ADDR_W      = 32,
   parameter int TOTAL_SLOTS = 32,
   parameter int RESV_SLOTS  = 1,
   localparam int USABLE     = TOTAL_SLOTS - RESV_SLOTS,
   localparam int CNT_W      = $clog2(USABLE + 1),
   localparam int PORT_W     = $clog2(NUM_PORTS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_PORTS-1:0]        cfg_port_hp,
   input  logic [CNT_W-1:0]            cfg_lo_entries,
   input  logic [NUM_PORTS-1:0]        req_valid,
   input  logic [NUM_PORTS*ADDR_W-1:0] req_addr,
   output logic [NUM_PORTS-1:0]        req_ready,
   input  logic                        ecc_req_valid,
   input  logic [ADDR_W-1:0]           ecc_req_addr,
   output logic                        ecc_req_ready,
   output logic                        lo_head_valid,
   output logic [ADDR_W-1:0]           lo_head_addr,
   output logic [PORT_W-1:0]           lo_head_port,
   input  logic                        lo_pop,
   output logic                        hi_head_valid,
   output logic [ADDR_W-1:0]           hi_head_addr,
   output logic [PORT_W-1:0]           hi_head_port,
   input  logic                        hi_pop,
   output logic                        ecc_head_valid,
   output logic [ADDR_W-1:0]           ecc_head_addr,
   input  logic                        ecc_pop
);

   localparam int ENT_W = PORT_W + ADDR_W;
   localparam logic [CNT_W-1:0] USABLE_C = CNT_W'(USABLE);

   // elaboration checks
   if (RESV_SLOTS != 1) begin : g_bad_resv
      $error("rdq_split: exactly one reserved slot is supported");
   end
   if (NUM_PORTS < 2 || NUM_PORTS > 32) begin : g_bad_ports
      $error("rdq_split: NUM_PORTS must be 2..32");
   end
   if (USABLE < 2) begin : g_bad_depth
      $error("rdq_split: TOTAL_SLOTS must be at least 3");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("rdq_split: ADDR_W must be positive");
   end

   // partition boundary
   logic [CNT_W-1:0] cfg_clamped;
   logic [CNT_W-1:0] part_q, part_eff;
   logic [CNT_W-1:0] lo_limit, hi_limit;
   logic             lo_empty, hi_empty, both_empty;
   logic             lo_credit, hi_credit;

   assign cfg_clamped = CNT_W'(clamp_share(int'(cfg_lo_entries), USABLE));
   assign both_empty  = lo_empty && hi_empty;
   assign part_eff    = both_empty ? cfg_clamped : part_q;
   assign lo_limit    = part_eff;
   assign hi_limit    = USABLE_C - part_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         part_q <= USABLE_C;
      end else begin
         part_q <= part_eff;
      end
   end

   // per-port class and fixed-priority arbitration within each class
   rdq_class_e           port_cls [NUM_PORTS];
   logic [NUM_PORTS-1:0] want_lo, want_hi;
   logic [NUM_PORTS-1:0] blocked_lo, blocked_hi;
   logic [NUM_PORTS-1:0] acc_lo, acc_hi;

   assign want_lo = req_valid & ~cfg_port_hp;
   assign want_hi = req_valid &  cfg_port_hp;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam logic [NUM_PORTS-1:0] LOWER = NUM_PORTS'((64'd1 << p) - 64'd1);
      assign port_cls[p]   = cfg_port_hp[p] ? CLS_HI : CLS_LO;
      assign blocked_lo[p] = |(want_lo & LOWER);
      assign blocked_hi[p] = |(want_hi & LOWER);
      assign req_ready[p]  = (port_cls[p] == CLS_HI) ? (hi_credit && !blocked_hi[p])
                                                     : (lo_credit && !blocked_lo[p]);
   end

   assign acc_lo = want_lo & req_ready;
   assign acc_hi = want_hi & req_ready;

   logic              lo_push, hi_push;
   logic [PORT_W-1:0] lo_sel, hi_sel;
   logic [ADDR_W-1:0] lo_addr_in, hi_addr_in;

   assign lo_push = |acc_lo;
   assign hi_push = |acc_hi;

   always_comb begin
      lo_sel = '0;
      hi_sel = '0;
      for (int p = NUM_PORTS - 1; p >= 0; p--) begin
         if (acc_lo[p]) lo_sel = PORT_W'(p);
         if (acc_hi[p]) hi_sel = PORT_W'(p);
      end
   end

   assign lo_addr_in = req_addr[lo_sel*ADDR_W +: ADDR_W];
   assign hi_addr_in = req_addr[hi_sel*ADDR_W +: ADDR_W];

   // credits and region rings
   logic             lo_pop_ok, hi_pop_ok;
   logic [CNT_W-1:0] lo_wr_idx, lo_rd_idx, hi_wr_idx, hi_rd_idx;

   assign lo_pop_ok = lo_pop && !lo_empty;
   assign hi_pop_ok = hi_pop && !hi_empty;

   rdq_credit #(.CNT_W(CNT_W)) u_lo_credit (
      .clk        (clk),
      .rst_n      (rst_n),
      .limit      (lo_limit),
      .push       (lo_push),
      .pop        (lo_pop),
      .has_credit (lo_credit),
      .empty      (lo_empty)
   );

   rdq_credit #(.CNT_W(CNT_W)) u_hi_credit (
      .clk        (clk),
      .rst_n      (rst_n),
      .limit      (hi_limit),
      .push       (hi_push),
      .pop        (hi_pop),
      .has_credit (hi_credit),
      .empty      (hi_empty)
   );

   rdq_ring #(.CNT_W(CNT_W)) u_lo_ring (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (both_empty),
      .base   ('0),
      .size   (lo_limit),
      .push   (lo_push),
      .pop    (lo_pop_ok),
      .wr_idx (lo_wr_idx),
      .rd_idx (lo_rd_idx)
   );

   rdq_ring #(.CNT_W(CNT_W)) u_hi_ring (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (both_empty),
      .base   (part_eff),
      .size   (hi_limit),
      .push   (hi_push),
      .pop    (hi_pop_ok),
      .wr_idx (hi_wr_idx),
      .rd_idx (hi_rd_idx)
   );

   // shared storage, low region below the boundary, high region above
   logic [ENT_W-1:0] slot_mem [USABLE];
   logic [ENT_W-1:0] lo_ent, hi_ent;

   always_ff @(posedge clk) begin
      if (lo_push) slot_mem[lo_wr_idx] <= {lo_sel, lo_addr_in};
      if (hi_push) slot_mem[hi_wr_idx] <= {hi_sel, hi_addr_in};
   end

   assign lo_ent        = slot_mem[lo_rd_idx];
   assign hi_ent        = slot_mem[hi_rd_idx];
   assign lo_head_valid = !lo_empty;
   assign hi_head_valid = !hi_empty;
   assign lo_head_addr  = lo_ent[ADDR_W-1:0];
   assign hi_head_addr  = hi_ent[ADDR_W-1:0];
   assign lo_head_port  = lo_ent[ENT_W-1:ADDR_W];
   assign hi_head_port  = hi_ent[ENT_W-1:ADDR_W];

   // reserved error-correction slot
   rdq_resv_slot #(.ADDR_W(ADDR_W)) u_resv (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (ecc_req_valid),
      .in_addr   (ecc_req_addr),
      .in_ready  (ecc_req_ready),
      .out_valid (ecc_head_valid),
      .out_addr  (ecc_head_addr),
      .out_pop   (ecc_pop)
   );

   p_one_lo_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(acc_lo));

   p_one_hi_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(acc_hi));

   p_partition_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((lo_head_valid || hi_head_valid) && !lo_pop && !hi_pop) |=> $stable(part_eff));

   p_regions_disjoint_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_push && hi_push) |-> (lo_wr_idx < hi_wr_idx));

endmodule

// File: tb/rdq_split_bench.sv
module rdq_split_bench;

   localparam int NP  = 4;
   localparam int AW  = 8;
   localparam int TS  = 7;
   localparam int USE = TS - 1;
   localparam int CW  = $clog2(USE + 1);
   localparam int PW  = $clog2(NP);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [NP-1:0]    cfg_hp = '0;
   logic [CW-1:0]    cfg_lo = CW'(USE);
   logic [NP-1:0]    req_valid = '0;
   logic [NP*AW-1:0] req_addr = '0;
   logic [NP-1:0]    req_ready;
   logic             ecc_req_valid = 1'b0;
   logic [AW-1:0]    ecc_req_addr = '0;
   logic             ecc_req_ready;
   logic             lo_head_valid, hi_head_valid, ecc_head_valid;
   logic [AW-1:0]    lo_head_addr, hi_head_addr, ecc_head_addr;
   logic [PW-1:0]    lo_head_port, hi_head_port;
   logic             lo_pop = 1'b0, hi_pop = 1'b0, ecc_pop = 1'b0;

   rdq_split #(.NUM_PORTS(NP), .ADDR_W(AW), .TOTAL_SLOTS(TS), .RESV_SLOTS(1)) u_rdq_split (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_port_hp    (cfg_hp),
      .cfg_lo_entries (cfg_lo),
      .req_valid      (req_valid),
      .req_addr       (req_addr),
      .req_ready      (req_ready),
      .ecc_req_valid  (ecc_req_valid),
      .ecc_req_addr   (ecc_req_addr),
      .ecc_req_ready  (ecc_req_ready),
      .lo_head_valid  (lo_head_valid),
      .lo_head_addr   (lo_head_addr),
      .lo_head_port   (lo_head_port),
      .lo_pop         (lo_pop),
      .hi_head_valid  (hi_head_valid),
      .hi_head_addr   (hi_head_addr),
      .hi_head_port   (hi_head_port),
      .hi_pop         (hi_pop),
      .ecc_head_valid (ecc_head_valid),
      .ecc_head_addr  (ecc_head_addr),
      .ecc_pop        (ecc_pop)
   );

   int vectors = 0;
   int miscompares = 0;

   // reference model state: entry = port * 256 + addr
   int lo_q[$];
   int hi_q[$];
   int part_reg = USE;
   bit ecc_full = 1'b0;
   int ecc_val = 0;

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int eff_part();
      if (lo_q.size() == 0 && hi_q.size() == 0)
         return (int'(cfg_lo) > USE) ? USE : int'(cfg_lo);
      return part_reg;
   endfunction

   // one clock: called just after a falling edge with inputs already set
   task automatic cycle();
      int e;
      int acc_lo;
      int acc_hi;
      bit old_full;
      acc_lo = -1;
      acc_hi = -1;
      #2;
      e = eff_part();
      for (int p = 0; p < NP; p++) begin
         bit hp;
         bit blocked;
         int sz;
         int lim;
         bit rdy;
         hp = cfg_hp[p];
         sz = hp ? hi_q.size() : lo_q.size();
         lim = hp ? (USE - e) : e;
         blocked = 1'b0;
         for (int q = 0; q < p; q++)
            if (req_valid[q] && (cfg_hp[q] == hp)) blocked = 1'b1;
         rdy = (sz < lim) && !blocked;
         chk("R3", $sformatf("ready port %0d", p), 32'(req_ready[p]), 32'(rdy));
         if (req_valid[p] && rdy) begin
            if (hp) acc_hi = p;
            else    acc_lo = p;
         end
      end
      chk("R5", "lo valid", 32'(lo_head_valid), 32'(lo_q.size() != 0));
      chk("R5", "hi valid", 32'(hi_head_valid), 32'(hi_q.size() != 0));
      if (lo_q.size() != 0) begin
         chk("R4", "lo addr", 32'(lo_head_addr), 32'(lo_q[0] % 256));
         chk("R4", "lo port", 32'(lo_head_port), 32'(lo_q[0] / 256));
      end
      if (hi_q.size() != 0) begin
         chk("R4", "hi addr", 32'(hi_head_addr), 32'(hi_q[0] % 256));
         chk("R4", "hi port", 32'(hi_head_port), 32'(hi_q[0] / 256));
      end
      chk("R7", "ecc ready", 32'(ecc_req_ready), 32'(!ecc_full));
      chk("R7", "ecc valid", 32'(ecc_head_valid), 32'(ecc_full));
      if (ecc_full) chk("R7", "ecc addr", 32'(ecc_head_addr), 32'(ecc_val));
      // state update
      if (lo_pop && lo_q.size() > 0) void'(lo_q.pop_front());
      if (hi_pop && hi_q.size() > 0) void'(hi_q.pop_front());
      if (acc_lo >= 0) lo_q.push_back(acc_lo * 256 + int'(req_addr[acc_lo*AW +: AW]));
      if (acc_hi >= 0) hi_q.push_back(acc_hi * 256 + int'(req_addr[acc_hi*AW +: AW]));
      old_full = ecc_full;
      if (!old_full && ecc_req_valid) begin
         ecc_full = 1'b1;
         ecc_val = int'(ecc_req_addr);
      end else if (old_full && ecc_pop) begin
         ecc_full = 1'b0;
      end
      part_reg = e;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      req_valid = '0;
      lo_pop = 1'b0;
      hi_pop = 1'b0;
      ecc_req_valid = 1'b0;
      ecc_pop = 1'b0;
   endtask

   task automatic drain();
      idle_inputs();
      lo_pop = 1'b1;
      hi_pop = 1'b1;
      ecc_pop = 1'b1;
      for (int i = 0; i < USE + 2; i++) cycle();
      idle_inputs();
   endtask

   task automatic traffic(input int n, input int vpct, input int ppct, input int cpct);
      for (int i = 0; i < n; i++) begin
         for (int p = 0; p < NP; p++) begin
            req_valid[p] = ($urandom_range(99) < vpct);
            req_addr[p*AW +: AW] = AW'($urandom);
         end
         lo_pop = ($urandom_range(99) < ppct);
         hi_pop = ($urandom_range(99) < ppct);
         ecc_req_valid = ($urandom_range(3) == 0);
         ecc_req_addr = AW'($urandom);
         ecc_pop = ($urandom_range(3) == 0);
         if ($urandom_range(99) < cpct) cfg_lo = CW'($urandom_range(USE + 1));
         if ($urandom_range(99) < 5) cfg_hp = NP'($urandom);
         cycle();
      end
      idle_inputs();
   endtask

   initial begin
      #(20 * 150000);
      miscompares++;
      $display("FAIL watchdog R3 actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R8", "lo valid after reset", 32'(lo_head_valid), 32'd0);
      chk("R8", "hi valid after reset", 32'(hi_head_valid), 32'd0);
      chk("R8", "ecc valid after reset", 32'(ecc_head_valid), 32'd0);
      chk("R8", "ecc ready after reset", 32'(ecc_req_ready), 32'd1);
      cycle();

      // R1: a setting above the usable count acts as the usable count
      cfg_lo = CW'(USE + 1);
      cfg_hp = '0;
      for (int i = 0; i < USE + 1; i++) begin
         req_valid = 4'b0001;
         req_addr[0 +: AW] = AW'(10 + i);
         cycle();
      end
      #1;
      chk("R1", "lo stalled at clamped share", 32'(req_ready[0]), 32'd0);
      chk("R4", "oldest lo addr", 32'(lo_head_addr), 32'd10);
      cfg_hp[1] = 1'b1;
      req_valid = 4'b0011;
      #1;
      chk("R1", "hi share empty", 32'(req_ready[1]), 32'd0);
      cycle();

      // R9: pop at the limit does not reopen ready in the same cycle
      req_valid = 4'b0001;
      req_addr[0 +: AW] = 8'd99;
      lo_pop = 1'b1;
      #1;
      chk("R9", "stalled during pop", 32'(req_ready[0]), 32'd0);
      cycle();
      lo_pop = 1'b0;
      #1;
      chk("R9", "credit back after pop", 32'(req_ready[0]), 32'd1);
      cycle();
      idle_inputs();

      // R6: boundary frozen while busy, applied once empty
      cfg_lo = CW'(2);
      req_valid = 4'b0010;
      req_addr[AW +: AW] = 8'd55;
      #1;
      chk("R6", "hi share still zero while busy", 32'(req_ready[1]), 32'd0);
      cycle();
      drain();
      req_valid = 4'b0010;
      #1;
      chk("R6", "new boundary after drain", 32'(req_ready[1]), 32'd1);
      cycle();

      // R10 and R2: one of each class in a single cycle
      req_valid = 4'b0011;
      req_addr[0 +: AW] = 8'd21;
      req_addr[AW +: AW] = 8'd22;
      #1;
      chk("R10", "lo accept together", 32'(req_ready[0]), 32'd1);
      chk("R10", "hi accept together", 32'(req_ready[1]), 32'd1);
      cycle();
      idle_inputs();
      #1;
      chk("R2", "hi head from hp port", 32'(hi_head_port), 32'd1);
      chk("R2", "lo head from lp port", 32'(lo_head_port), 32'd0);
      cycle();
      drain();

      // R7: reserved slot independent of full classes
      req_valid = 4'b0001;
      for (int i = 0; i < 3; i++) cycle();
      ecc_req_valid = 1'b1;
      ecc_req_addr = 8'hA5;
      #1;
      chk("R7", "ecc accepted with lo full", 32'(ecc_req_ready), 32'd1);
      cycle();
      ecc_req_valid = 1'b0;
      #1;
      chk("R7", "lo still stalled", 32'(req_ready[0]), 32'd0);
      chk("R7", "ecc head held", 32'(ecc_head_addr), 32'hA5);
      cycle();
      drain();

      // sweeps over every boundary value with random traffic
      for (int c = 0; c <= USE + 1; c++) begin
         cfg_lo = CW'(c);
         cfg_hp = NP'($urandom);
         traffic(150, 70, 25, 0);
         traffic(150, 30, 70, 0);
         traffic(100, 50, 50, 10);
         drain();
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule